// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit executes the instruction that configures vector lengths. Each instruction carries a 7-bit length immediate, a source-select bit and three mode bits. From these the unit computes a new ceiling on vector length (the maximum length) and a new active length. The active length can come from the immediate, from a general-register operand, or from the loop-count register. The unit holds both lengths and a vertical-first flag as architectural state. It returns the resulting active length to a destination register when one is named, and it can also write a 4-bit condition field.

The instruction is presented on `insn` together with a one-cycle `issue_valid` strobe. The operand values are supplied on `ra_value` and `ctr_value`. All state changes and write-back strobes appear on the clock edge that samples the strobe, so results are visible in the following cycle. An explicitly requested active length is always honoured exactly, limited only by the maximum length. The hardware never chooses a smaller value of its own.

Top module: `vlcfg_unit`

## Requirements
- R1: After reset, the maximum length, the active length and the vertical-first flag read 0, and neither write strobe (`rt_we`, `cr_we`) is asserted.
- R2: Fields use big-endian bit numbering, with bit 0 the MSB of `insn`. The fields are: destination register number in bits 6..10 (`insn[25:21]`), source register number in bits 11..15 (`insn[20:16]`), length immediate in bits 16..22 (`insn[15:9]`), source-select in bit 22 (`insn[9]`, which is shared with the immediate's LSB), maximum-length write enable in bit 23 (`insn[8]`), active-length write enable in bit 24 (`insn[7]`), vertical-first in bit 25 (`insn[6]`), and condition enable in bit 31 (`insn[0]`).
- R3: The immediate is biased by one: a field value k gives a length of k+1, saturated at 64. A field of 0 gives 1, and 63 or more gives 64. This path never produces a length of 0.
- R4: With both length write enables set, the maximum length and the active length are loaded from the same immediate in one instruction.
- R5: With the active-length write enable set, source-select clear and a nonzero source register number, the active length becomes min(saturate64(`ra_value`), maximum length).
- R6: With the active-length write enable and source-select set, the active length becomes min(saturate64(`ctr_value`), maximum length), and `ra_value` has no effect.
- R7: With the active-length write enable set, source-select clear and source register number 0, the active length comes from the immediate, clamped by the maximum length, and `ra_value` has no effect.
- R8: With the active-length write enable clear, the active length keeps its value unless a newly written maximum length is smaller, in which case it drops to the new maximum. With the maximum-length write enable clear, the maximum length keeps its value.
- R9: When all three mode bits are 0, no state changes and the current active length is returned to the destination register.
- R10: When the destination register number is nonzero, `rt_we` pulses for one cycle with `rt_addr` set to that number and `rt_data` set to the resulting active length, zero-extended. When the destination number is 0, `rt_we` stays low.
- R11: When the condition enable is set, `cr_we` pulses and `cr_field` is written from the resulting active length as {LT, GT, EQ, SO}: 4'b0010 for a length of 0 and 4'b0100 otherwise.
- R12: Any instruction with at least one mode bit set loads the vertical-first flag from bit 25. An instruction with only that bit set leaves both lengths unchanged.
- R13: At all times the active length does not exceed the maximum length, and the maximum length does not exceed 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | One-cycle strobe: `insn` holds a configuration instruction |
| insn | input | 32 | Instruction word |
| ra_value | input | XLEN | Value of the source register operand |
| ctr_value | input | XLEN | Value of the loop-count register |
| mvl_out | output | 7 | Current maximum vector length |
| vl_out | output | 7 | Current active vector length |
| vert_first_out | output | 1 | Vertical-first mode flag |
| rt_we | output | 1 | Destination register write strobe |
| rt_addr | output | 5 | Destination register number |
| rt_data | output | XLEN | Resulting active length, zero-extended |
| cr_we | output | 1 | Condition field write strobe |
| cr_field | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The bench builds the unit with its default parameters: a 64-bit operand width and a ceiling of 64. With these values, register operands far above the ceiling (up to 2^40) can be applied, which reaches the saturation path. Immediates of 63 and 127 exercise both saturation of the biased immediate and the largest legal length. The ceiling of 64 can be reached from every source, and a ceiling of 1 can be reached from a zero immediate. Because the immediate's LSB is the source-select bit, the loop-count tests use odd immediates and the register and immediate tests use even ones.

// File: rtl/vlcfg_pkg.sv
// Package: shared types for the vector length configuration unit.
// Assumes a 32-bit instruction word with big-endian field numbering.
package vlcfg_pkg;
    localparam int IMM_W = 7;
    localparam int REG_W = 5;

    // Decoded instruction fields
    typedef struct packed {
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] ra;
        logic [IMM_W-1:0] imm;
        logic             use_ctr;
        logic             set_mvl;
        logic             set_vl;
        logic             vert_first;
        logic             rc;
    } vlcfg_fields_t;
endpackage

// File: rtl/vlcfg_decode.sv
// Module: vlcfg_decode
// Pulls the register numbers, the length immediate and the control bits out
// of the instruction word. Bit 0 of the format is insn[31].
// Assumes: the caller has already identified the opcode.
module vlcfg_decode
    import vlcfg_pkg::*;
(
    input  logic [31:0]   insn,
    output vlcfg_fields_t fields
);
    // Field extraction: format bit k maps to insn[31-k]
    always_comb begin
        fields.rt         = insn[25:21];
        fields.ra         = insn[20:16];
        fields.imm        = insn[15:9];
        fields.use_ctr    = insn[9];
        fields.set_mvl    = insn[8];
        fields.set_vl     = insn[7];
        fields.vert_first = insn[6];
        fields.rc         = insn[0];
    end
endmodule

// File: rtl/vlcfg_sat.sv
// Module: vlcfg_sat
// Saturates an unsigned source value to the length ceiling MAX_LEN.
// Assumes: SRC_W >= LEN_W.
module vlcfg_sat #(
    parameter int SRC_W   = 64,
    parameter int MAX_LEN = 64,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic [SRC_W-1:0] src,
    output logic [LEN_W-1:0] len
);
    // Clip to the ceiling, otherwise pass the low bits through
    always_comb begin
        if (src > SRC_W'(MAX_LEN)) len = LEN_W'(MAX_LEN);
        else                       len = src[LEN_W-1:0];
    end
endmodule

// File: rtl/vlcfg_next.sv
// Module: vlcfg_next
// Computes the next maximum length, active length and vertical-first flag
// from the decoded controls and the three saturated length sources.
// Assumes: cur_vl <= cur_mvl, and all source lengths are at most the ceiling.
module vlcfg_next #(
    parameter int LEN_W = 7
) (
    input  logic             set_mvl,
    input  logic             set_vl,
    input  logic             vert_first,
    input  logic             use_ctr,
    input  logic             ra_named,
    input  logic [LEN_W-1:0] imm_len,
    input  logic [LEN_W-1:0] ra_len,
    input  logic [LEN_W-1:0] ctr_len,
    input  logic [LEN_W-1:0] cur_mvl,
    input  logic [LEN_W-1:0] cur_vl,
    input  logic             cur_vf,
    output logic [LEN_W-1:0] nxt_mvl,
    output logic [LEN_W-1:0] nxt_vl,
    output logic             nxt_vf
);
    logic [LEN_W-1:0] req_len;
    logic             any_mode;

    // Pick the new maximum length: the immediate or the held value
    always_comb nxt_mvl = set_mvl ? imm_len : cur_mvl;

    // Pick the requested active length from its source
    always_comb begin
        if (!set_vl)      req_len = cur_vl;
        else if (use_ctr) req_len = ctr_len;
        else if (ra_named) req_len = ra_len;
        else              req_len = imm_len;
    end

    // Clamp the request by the new maximum length only
    always_comb nxt_vl = (req_len < nxt_mvl) ? req_len : nxt_mvl;

    // Vertical-first flag follows bit 25 whenever any mode bit is set
    always_comb begin
        any_mode = set_mvl | set_vl | vert_first;
        nxt_vf   = any_mode ? vert_first : cur_vf;
    end
endmodule

// File: rtl/vlcfg_unit.sv
// Module: vlcfg_unit (top)
// Executes the vector length configuration instruction: decodes the fields,
// saturates the three length sources, computes the new lengths and holds the
// state. Write-back strobes are registered and last one cycle.
// Assumes: issue_valid is a single-cycle strobe per instruction; XLEN >= 7.
module vlcfg_unit
    import vlcfg_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int MAX_LEN = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              issue_valid,
    input  logic [31:0]                       insn,
    input  logic [XLEN-1:0]                   ra_value,
    input  logic [XLEN-1:0]                   ctr_value,
    output logic [$clog2(MAX_LEN + 1)-1:0]    mvl_out,
    output logic [$clog2(MAX_LEN + 1)-1:0]    vl_out,
    output logic                              vert_first_out,
    output logic                              rt_we,
    output logic [REG_W-1:0]                  rt_addr,
    output logic [XLEN-1:0]                   rt_data,
    output logic                              cr_we,
    output logic [3:0]                        cr_field
);
    localparam int LEN_W = $clog2(MAX_LEN + 1);
    localparam int NSRC  = 3;   // immediate, register, loop count

    vlcfg_fields_t    f;
    logic [XLEN-1:0]  src_val [NSRC];
    logic [LEN_W-1:0] src_len [NSRC];
    logic [LEN_W-1:0] nxt_mvl;
    logic [LEN_W-1:0] nxt_vl;
    logic             nxt_vf;
    logic             any_mode;

    vlcfg_decode u_decode (
        .insn   (insn),
        .fields (f)
    );

    // Gather the raw sources; the immediate carries its +1 bias here
    always_comb begin
        src_val[0] = XLEN'(f.imm) + XLEN'(1);
        src_val[1] = ra_value;
        src_val[2] = ctr_value;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_sat
        vlcfg_sat #(
            .SRC_W   (XLEN),
            .MAX_LEN (MAX_LEN),
            .LEN_W   (LEN_W)
        ) u_sat (
            .src (src_val[g]),
            .len (src_len[g])
        );
    end

    vlcfg_next #(
        .LEN_W (LEN_W)
    ) u_next (
        .set_mvl    (f.set_mvl),
        .set_vl     (f.set_vl),
        .vert_first (f.vert_first),
        .use_ctr    (f.use_ctr),
        .ra_named   (f.ra != '0),
        .imm_len    (src_len[0]),
        .ra_len     (src_len[1]),
        .ctr_len    (src_len[2]),
        .cur_mvl    (mvl_out),
        .cur_vl     (vl_out),
        .cur_vf     (vert_first_out),
        .nxt_mvl    (nxt_mvl),
        .nxt_vl     (nxt_vl),
        .nxt_vf     (nxt_vf)
    );

    // Flag an instruction that may modify state
    always_comb any_mode = f.set_mvl | f.set_vl | f.vert_first;

    // Architectural length state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mvl_out        <= '0;
            vl_out         <= '0;
            vert_first_out <= 1'b0;
        end else if (issue_valid && any_mode) begin
            mvl_out        <= nxt_mvl;
            vl_out         <= nxt_vl;
            vert_first_out <= nxt_vf;
        end
    end

    // Destination register write-back, one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_we   <= 1'b0;
            rt_addr <= '0;
            rt_data <= '0;
        end else begin
            rt_we <= issue_valid && (f.rt != '0);
            if (issue_valid) begin
                rt_addr <= f.rt;
                rt_data <= XLEN'(nxt_vl);
            end
        end
    end

    // Condition field from the resulting active length {LT, GT, EQ, SO}
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_we    <= 1'b0;
            cr_field <= '0;
        end else begin
            cr_we <= issue_valid && f.rc;
            if (issue_valid && f.rc)
                cr_field <= {1'b0, nxt_vl != '0, nxt_vl == '0, 1'b0};
        end
    end
endmodule

// File: rtl/vlcfg_unit_chk.sv
// Module: vlcfg_unit_chk
// Property checker for vlcfg_unit, attached through the bind below.
module vlcfg_unit_chk #(
    parameter int XLEN    = 64,
    parameter int MAX_LEN = 64,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue_valid,
    input logic [31:0]      insn,
    input logic [LEN_W-1:0] mvl_out,
    input logic [LEN_W-1:0] vl_out,
    input logic             vert_first_out,
    input logic             rt_we,
    input logic [XLEN-1:0]  rt_data,
    input logic             cr_we,
    input logic [3:0]       cr_field
);
    a_r13_vl_within_mvl: assert property (@(posedge clk) disable iff (!rst_n)
        vl_out <= mvl_out);

    a_r13_mvl_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        mvl_out <= LEN_W'(MAX_LEN));

    a_r9_query_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && insn[8:6] == 3'b000 |=>
            $stable(mvl_out) && $stable(vl_out) && $stable(vert_first_out));

    a_r8_mvl_held: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !insn[8] |=> $stable(mvl_out));

    a_r8_vl_held: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !insn[8] && !insn[7] |=> $stable(vl_out));

    a_r3_imm_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && insn[8] |=> mvl_out != '0);

    a_r10_rt_carries_vl: assert property (@(posedge clk) disable iff (!rst_n)
        rt_we |-> rt_data == XLEN'(vl_out));

    a_r10_rt_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && insn[25:21] == 5'd0 |=> !rt_we);

    a_r11_cr_from_vl: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> cr_field[1] == (vl_out == '0) && cr_field[2] == (vl_out != '0)
                  && !cr_field[3] && !cr_field[0]);

    a_r1_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> !rt_we && !cr_we && $stable(mvl_out) && $stable(vl_out));
endmodule

bind vlcfg_unit vlcfg_unit_chk #(
    .XLEN    (XLEN),
    .MAX_LEN (MAX_LEN)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .issue_valid    (issue_valid),
    .insn           (insn),
    .mvl_out        (mvl_out),
    .vl_out         (vl_out),
    .vert_first_out (vert_first_out),
    .rt_we          (rt_we),
    .rt_data        (rt_data),
    .cr_we          (cr_we),
    .cr_field       (cr_field)
);

// File: tb/test_vlcfg_unit.sv
`timescale 1ns/1ps
// Directed bench for vlcfg_unit: one task per scenario, own reference model.
module test_vlcfg_unit;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue_valid = 1'b0;
    logic [31:0]     insn = '0;
    logic [XLEN-1:0] ra_value = '0;
    logic [XLEN-1:0] ctr_value = '0;
    logic [6:0]      mvl_out;
    logic [6:0]      vl_out;
    logic            vert_first_out;
    logic            rt_we;
    logic [4:0]      rt_addr;
    logic [XLEN-1:0] rt_data;
    logic            cr_we;
    logic [3:0]      cr_field;

    int nchecks = 0;
    int nerrors = 0;
    bit done = 0;

    // Reference state
    int exp_mvl = 0;
    int exp_vl  = 0;
    int exp_vf  = 0;

    vlcfg_unit #(.XLEN(XLEN), .MAX_LEN(64)) i_vlcfg_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .insn(insn),
        .ra_value(ra_value), .ctr_value(ctr_value), .mvl_out(mvl_out),
        .vl_out(vl_out), .vert_first_out(vert_first_out), .rt_we(rt_we),
        .rt_addr(rt_addr), .rt_data(rt_data), .cr_we(cr_we), .cr_field(cr_field)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input longint act, input longint exp);
        nchecks++;
        if (act != exp) begin
            nerrors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat64(input longint unsigned v);
        return (v > 64) ? 64 : int'(v);
    endfunction

    // Encode fields at their big-endian positions (R2)
    function automatic logic [31:0] enc(input int rt, input int ra, input int imm,
                                        input bit ms, input bit vs, input bit vf,
                                        input bit rc);
        logic [31:0] w = '0;
        w[25:21] = 5'(rt);
        w[20:16] = 5'(ra);
        w[15:9]  = 7'(imm);
        w[8]     = ms;
        w[7]     = vs;
        w[6]     = vf;
        w[0]     = rc;
        return w;
    endfunction

    // Issue one instruction, update the model, check every output
    task automatic run(input string tag, input int rt, input int ra, input int imm,
                       input bit ms, input bit vs, input bit vf, input bit rc,
                       input longint unsigned rav, input longint unsigned ctrv);
        int imm_len, new_mvl, req, new_vl;
        imm_len = sat64(longint'(imm) + 1);
        new_mvl = ms ? imm_len : exp_mvl;
        if (!vs)              req = exp_vl;
        else if (imm[0])      req = sat64(ctrv);
        else if (ra != 0)     req = sat64(rav);
        else                  req = imm_len;
        new_vl = (req < new_mvl) ? req : new_mvl;
        if (ms || vs || vf) begin
            exp_mvl = new_mvl;
            exp_vl  = new_vl;
            exp_vf  = vf;
        end
        @(negedge clk);
        insn = enc(rt, ra, imm, ms, vs, vf, rc);
        ra_value = rav;
        ctr_value = ctrv;
        issue_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        issue_valid = 1'b0;
        check({tag, " mvl"}, mvl_out, exp_mvl);
        check({tag, " vl"}, vl_out, exp_vl);
        check({tag, " vf"}, vert_first_out, exp_vf);
        check({tag, " R13 vl<=mvl"}, vl_out <= mvl_out, 1);
        check({tag, " R10 rt_we"}, rt_we, rt != 0);
        if (rt != 0) begin
            check({tag, " R10 rt_addr"}, rt_addr, rt);
            check({tag, " R10 rt_data"}, longint'(rt_data), exp_vl);
        end
        check({tag, " R11 cr_we"}, cr_we, rc);
        if (rc) check({tag, " R11 cr"}, cr_field, (exp_vl == 0) ? 4'b0010 : 4'b0100);
    endtask

    task automatic t_reset();
        check("R1 mvl", mvl_out, 0);
        check("R1 vl", vl_out, 0);
        check("R1 vf", vert_first_out, 0);
        check("R1 rt_we", rt_we, 0);
        check("R1 cr_we", cr_we, 0);
    endtask

    task automatic t_imm_bias();
        run("R3 imm0", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        check("R3 zero field gives 1", mvl_out, 1);
        run("R3 imm63", 0, 0, 63, 1, 0, 0, 0, 0, 0);
        check("R3 63 gives 64", mvl_out, 64);
        run("R3 imm127", 0, 0, 127, 1, 0, 0, 0, 0, 0);
        check("R3 127 saturates", mvl_out, 64);
    endtask

    task automatic t_both_imm();
        run("R4 both", 0, 0, 62, 1, 1, 0, 0, 0, 0);
        check("R4 mvl", mvl_out, 63);
        check("R4 vl", vl_out, 63);
        run("R4 both small", 0, 0, 2, 1, 1, 0, 0, 0, 0);
        check("R4 vl3", vl_out, 3);
    endtask

    task automatic t_ra_source();
        run("R5 mvl8", 0, 0, 7, 1, 0, 0, 0, 0, 0);
        run("R5 ra5", 4, 3, 0, 0, 1, 0, 0, 5, 0);
        check("R5 exact request", vl_out, 5);
        run("R5 ra20 clamp", 4, 3, 0, 0, 1, 0, 0, 20, 0);
        check("R5 clamped to mvl", vl_out, 8);
        run("R5 ra huge", 4, 3, 0, 0, 1, 0, 0, 64'd1 << 40, 0);
        check("R5 saturated", vl_out, 8);
        run("R5 mvl64", 0, 0, 63, 1, 0, 0, 0, 0, 0);
        run("R5 ra1000", 4, 3, 0, 0, 1, 0, 0, 1000, 0);
        check("R5 sat to 64", vl_out, 64);
        run("R5 ra0", 4, 3, 0, 0, 1, 0, 1, 0, 0);
        check("R5 zero length", vl_out, 0);
    endtask

    task automatic t_ctr_source();
        run("R6 ctr7", 6, 3, 1, 0, 1, 0, 0, 2, 7);
        check("R6 ctr wins over ra", vl_out, 7);
        run("R6 ctr huge", 6, 3, 1, 0, 1, 0, 0, 2, 64'hFFFF_FFFF);
        check("R6 ctr saturated", vl_out, 64);
    endtask

    task automatic t_imm_vl();
        run("R7 imm4 ra0", 0, 0, 4, 0, 1, 0, 0, 30, 0);
        check("R7 ra ignored", vl_out, 5);
    endtask

    task automatic t_mvl_shrink();
        run("R8 vl40", 0, 2, 0, 0, 1, 0, 0, 40, 0);
        run("R8 shrink", 0, 0, 9, 1, 0, 0, 0, 0, 0);
        check("R8 vl cut to new mvl", vl_out, 10);
        run("R8 grow", 0, 0, 62, 1, 0, 0, 0, 0, 0);
        check("R8 vl kept", vl_out, 10);
    endtask

    task automatic t_query();
        run("R9 getvl", 5, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R9 rt_data", longint'(rt_data), 10);
        check("R9 mvl unchanged", mvl_out, 63);
    endtask

    task automatic t_rt_zero();
        run("R10 rt0", 0, 0, 0, 0, 0, 0, 1, 0, 0);
        @(negedge clk);
        check("R10 idle no write", rt_we, 0);
        check("R11 idle no cr", cr_we, 0);
    endtask

    task automatic t_vertical();
        run("R12 vf only", 0, 0, 5, 0, 0, 1, 0, 0, 0);
        check("R12 flag set", vert_first_out, 1);
        check("R12 vl unchanged", vl_out, 10);
        run("R12 getvl keeps", 7, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R12 flag kept", vert_first_out, 1);
        run("R12 clear", 0, 0, 3, 1, 0, 0, 1, 0, 0);
        check("R12 flag cleared", vert_first_out, 0);
        check("R11 cr gt", cr_field, 4'b0100);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_imm_bias();
        t_both_imm();
        t_ra_source();
        t_ctr_source();
        t_imm_vl();
        t_mvl_shrink();
        t_query();
        t_rt_zero();
        t_vertical();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", nchecks, nerrors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            nchecks++;
            nerrors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", nchecks, nerrors);
            $finish;
        end
    end
endmodule